// File: doc/BRIEF.md
# Bus Alert Aggregator with Alert-Response Slave

This block combines the fault flags of a monitoring device into one shared alert line for an SMBus-style 2-wire bus. Five fixed fault sources and a parameterised set of GPIO faults feed the line. A GPIO counts only when it is configured to act as a fault output. The alert is live and not latched: it follows the fault inputs, gated by a global enable, and drops only when every contributing source has gone inactive. The output is a pull-down enable for an open-drain, active-low line, so several devices can share the wire.

A small 2-wire slave runs beside the aggregator. It oversamples SCL and SDA from the system clock, finds START and STOP conditions and watches for the fixed Alert Response Address. When that address arrives while the device's own alert is active, the slave acknowledges it. It then returns the device's own 7-bit address, driving SDA low only for zero bits. If another responder wins a bit, the slave withdraws for the rest of the transfer. The master uses this exchange to learn which device pulled the alert line.

Top module: `smba_alert_top`

## Requirements
- R1: With the global enable high, `alert_pull_o` is 1 whenever any of the five fixed fault flags (`fault1_i`, `fault2_i`, `rst_flag_i`, `ovt_i`, `ovc_i`) is 1. It is registered, with one system-clock cycle of latency.
- R2: A GPIO fault bit raises the alert only when its matching `gpio_is_fault_i` bit is 1. An active GPIO fault on an unconfigured pin leaves `alert_pull_o` at 0.
- R3: `alert_pull_o` returns to 0 only once every fixed flag and every configured GPIO fault is inactive. With the global enable low it is always 0.
- R4: `alert_pull_o` = 1 means the active-low line is pulled low, and `sda_oe_o` = 1 means SDA is pulled low. Neither output ever drives a high level.
- R5: SCL and SDA pass through two synchronizing flops. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The system clock runs at least 16 times the SCL rate, which covers 400 kHz buses.
- R6: An address byte whose upper seven bits are 0001100 matches, whatever the value of bit 0 (R/W). If the alert is active when the byte ends, the slave pulls SDA low during the ninth clock.
- R7: If the alert is inactive, or the address differs from 0001100, the slave leaves SDA released during the acknowledge clock and for the rest of the transfer.
- R8: After the acknowledge, the slave returns the byte {own_addr[6:0], 0}, MSB first, over eight SCL clocks. It pulls SDA low only for 0 bits.
- R9: If the slave has released SDA for a 1 bit but sees SDA low while SCL is high, it has lost arbitration. It keeps SDA released for the rest of that transfer.
- R10: Answering the Alert Response Address does not clear the alert. `alert_pull_o` keeps following the fault inputs.
- R11: A STOP or a repeated START at any point returns the slave to idle with SDA released. A START also restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fault1_i | input | 1 | General fault output 1 active |
| fault2_i | input | 1 | General fault output 2 active |
| rst_flag_i | input | 1 | Reset output active |
| ovt_i | input | 1 | Over-temperature output active |
| ovc_i | input | 1 | Over-current output active |
| gpio_fault_i | input | NGPIO | Per-GPIO fault active |
| gpio_is_fault_i | input | NGPIO | Per-GPIO "used as fault output" configuration |
| alert_en_i | input | 1 | Global alert enable |
| own_addr_i | input | 7 | Device's own 7-bit slave address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired result) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| alert_pull_o | output | 1 | 1 pulls the active-low alert line low |

## Verification
The hardest state to reach is arbitration loss in the middle of the returned address. It needs a second responder pulling SDA low on exactly the bit where this device has released it. The bench models SDA as a wired AND of the master and the design. During the read it forces a zero on a chosen bit where the own address holds a one, and then expects all later bits to read back as ones. Repeated START and STOP in the middle of a transfer are reached in a similar way. The bench breaks a transfer at a point where the design has SDA released, and then runs a full exchange to show that the slave recovered.

// File: rtl/smba_pkg.sv
package smba_pkg;
    localparam logic [6:0] ARA_ADDR  = 7'b0001100;
    localparam int         NUM_FIXED = 5;
    localparam int         BIT_CNT_W = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACKW,
        S_ACK,
        S_SEND
    } slv_state_e;

    typedef struct packed {
        logic level;
        logic prev;
    } line_ev_t;

    function automatic logic ara_match(input logic [6:0] addr);
        return addr == ARA_ADDR;
    endfunction
endpackage

// File: rtl/smba_line_sync.sv
module smba_line_sync
    import smba_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output line_ev_t ev_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], line_i};
    end

    assign ev_o.level = chain[STAGES-1];
    assign ev_o.prev  = chain[STAGES];
endmodule

// File: rtl/smba_alert_or.sv
module smba_alert_or
    import smba_pkg::*;
#(
    parameter int NGPIO = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FIXED-1:0] fixed_i,
    input  logic [NGPIO-1:0]     gpio_fault_i,
    input  logic [NGPIO-1:0]     gpio_cfg_i,
    input  logic                 en_i,
    output logic                 pull_o
);
    logic any_fault;

    assign any_fault = (|fixed_i) | (|(gpio_fault_i & gpio_cfg_i));

    always_ff @(posedge clk) begin
        if (rst) pull_o <= 1'b0;
        else     pull_o <= en_i & any_fault;
    end

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !pull_o);
    assert_fixed_raises_R1: assert property (@(posedge clk) disable iff (rst)
        (en_i && (|fixed_i)) |=> pull_o);
    assert_unconfigured_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        ((fixed_i == '0) && ((gpio_fault_i & gpio_cfg_i) == '0)) |=> !pull_o);
endmodule

// File: rtl/smba_ara_slave.sv
module smba_ara_slave
    import smba_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   scl,
    input  line_ev_t   sda,
    input  logic       alert_i,
    input  logic [6:0] own_addr_i,
    output logic       sda_oe_o
);
    slv_state_e           state;
    logic [BIT_CNT_W-1:0] cnt;
    logic [6:0]           addr_sr;
    logic [6:0]           tx_rest;
    logic                 scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl.level & ~scl.prev;
    assign scl_fall = ~scl.level & scl.prev;
    assign start_c  = scl.level & scl.prev & sda.prev & ~sda.level;
    assign stop_c   = scl.level & scl.prev & ~sda.prev & sda.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            sda_oe_o <= 1'b0;
            cnt      <= '0;
            addr_sr  <= '0;
            tx_rest  <= '0;
        end else if (start_c) begin
            state    <= S_ADDR;
            sda_oe_o <= 1'b0;
            cnt      <= '0;
        end else if (stop_c) begin
            state    <= S_IDLE;
            sda_oe_o <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: sda_oe_o <= 1'b0;
                S_ADDR: if (scl_rise) begin
                    addr_sr <= {addr_sr[5:0], sda.level};
                    cnt     <= cnt + 1'b1;
                    if (cnt == '1)
                        state <= (ara_match(addr_sr) && alert_i) ? S_ACKW : S_IDLE;
                end
                S_ACKW: if (scl_fall) begin
                    sda_oe_o <= 1'b1;
                    state    <= S_ACK;
                end
                S_ACK: if (scl_fall) begin
                    tx_rest  <= {own_addr_i[5:0], 1'b0};
                    sda_oe_o <= ~own_addr_i[6];
                    cnt      <= '0;
                    state    <= S_SEND;
                end
                S_SEND: begin
                    if (scl_rise && !sda_oe_o && !sda.level) begin
                        state <= S_IDLE;
                    end else if (scl_fall) begin
                        if (cnt == '1) begin
                            sda_oe_o <= 1'b0;
                            state    <= S_IDLE;
                        end else begin
                            cnt      <= cnt + 1'b1;
                            sda_oe_o <= ~tx_rest[6];
                            tx_rest  <= {tx_rest[5:0], 1'b0};
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
        (stop_c || start_c) |=> !sda_oe_o);
    assert_drive_only_when_owed_R7: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> (state == S_ACK || state == S_SEND));
    assert_ack_needs_alert_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADDR && scl_rise && cnt == '1 && !alert_i && !start_c && !stop_c)
        |=> state == S_IDLE);
    assert_arb_loss_backs_off_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_SEND && scl_rise && !sda_oe_o && !sda.level && !start_c && !stop_c)
        |=> (state == S_IDLE && !sda_oe_o));
endmodule

// File: rtl/smba_alert_top.sv
module smba_alert_top
    import smba_pkg::*;
#(
    parameter int NGPIO       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault1_i,
    input  logic             fault2_i,
    input  logic             rst_flag_i,
    input  logic             ovt_i,
    input  logic             ovc_i,
    input  logic [NGPIO-1:0] gpio_fault_i,
    input  logic [NGPIO-1:0] gpio_is_fault_i,
    input  logic             alert_en_i,
    input  logic [6:0]       own_addr_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic             alert_pull_o
);
    line_ev_t scl_ev, sda_ev;

    smba_alert_or #(.NGPIO(NGPIO)) u_or (
        .clk          (clk),
        .rst          (rst),
        .fixed_i      ({fault1_i, fault2_i, rst_flag_i, ovt_i, ovc_i}),
        .gpio_fault_i (gpio_fault_i),
        .gpio_cfg_i   (gpio_is_fault_i),
        .en_i         (alert_en_i),
        .pull_o       (alert_pull_o)
    );

    smba_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .ev_o(scl_ev));
    smba_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .ev_o(sda_ev));

    smba_ara_slave u_slave (
        .clk        (clk),
        .rst        (rst),
        .scl        (scl_ev),
        .sda        (sda_ev),
        .alert_i    (alert_pull_o),
        .own_addr_i (own_addr_i),
        .sda_oe_o   (sda_oe_o)
    );
endmodule

// File: tb/test_smba_alert_top.sv
module test_smba_alert_top;
    localparam int NG = 4;
    localparam int Q  = 10;
    localparam logic [6:0] ARA = 7'b0001100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic f1 = 0, f2 = 0, fr = 0, fot = 0, foc = 0, en = 0;
    logic [NG-1:0] gf = '0, gc = '0;
    logic [6:0] own = 7'h2A;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, alert_pull;
    logic sda_line;
    int checks = 0, fails = 0;
    bit done = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    smba_alert_top #(.NGPIO(NG)) i_smba_alert_top (
        .clk(clk), .rst(rst), .fault1_i(f1), .fault2_i(f2), .rst_flag_i(fr),
        .ovt_i(fot), .ovc_i(foc), .gpio_fault_i(gf), .gpio_is_fault_i(gc),
        .alert_en_i(en), .own_addr_i(own), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .alert_pull_o(alert_pull));

    function automatic logic exp_alert();
        return en & (f1 | f2 | fr | fot | foc | (|(gf & gc)));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; waitq(Q); m_scl = 1; waitq(Q); m_sda = 0; waitq(Q); m_scl = 0; waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; waitq(Q); m_scl = 1; waitq(Q); m_sda = 1; waitq(Q);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        m_sda = b; waitq(Q); m_scl = 1; waitq(Q); s = sda_line; waitq(Q); m_scl = 0; waitq(Q);
    endtask

    // full exchange: address byte, ack bit, eight read bits, master nack, stop
    task automatic ara_txn(input logic [7:0] ab, input int force_bit,
                           output logic ack_low, output logic [7:0] rd);
        logic s;
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(ab[i], s);
        bus_bit(1'b1, ack_low);
        ack_low = ~ack_low;
        for (int i = 7; i >= 0; i--) begin
            bus_bit((i == force_bit) ? 1'b0 : 1'b1, s);
            rd[i] = s;
        end
        bus_bit(1'b1, s);
        bus_stop();
    endtask

    task automatic set_faults(input logic [4:0] fx, input logic [NG-1:0] g, input logic [NG-1:0] c,
                              input logic e);
        {f1, f2, fr, fot, foc} = fx; gf = g; gc = c; en = e;
        waitq(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rd;
        logic s;
        logic [4:0] fx;
        logic [7:0] ab;
        void'($urandom(32'd1234));
        waitq(4);
        rst = 0;
        waitq(2);
        chk("R4 reset alert", alert_pull, 0);
        chk("R4 reset sda", sda_oe, 0);

        // R1: each fixed source alone
        for (int k = 0; k < 5; k++) begin
            set_faults(5'b1 << k, '0, '0, 1'b1);
            chk("R1 single fixed source", alert_pull, 1);
        end
        // R2: unconfigured GPIO fault ignored, configured one counts
        set_faults(5'b0, 4'b1111, 4'b0000, 1'b1);
        chk("R2 unconfigured gpio", alert_pull, 0);
        set_faults(5'b0, 4'b0100, 4'b0100, 1'b1);
        chk("R2 configured gpio", alert_pull, 1);
        // R3: disable masks everything; deassert only when all clear
        set_faults(5'b11111, 4'b1111, 4'b1111, 1'b0);
        chk("R3 disabled", alert_pull, 0);
        set_faults(5'b00010, 4'b0001, 4'b0001, 1'b1);
        set_faults(5'b00000, 4'b0001, 4'b0001, 1'b1);
        chk("R3 partial clear keeps alert", alert_pull, 1);
        set_faults(5'b00000, 4'b0001, 4'b0000, 1'b1);
        chk("R3 all clear", alert_pull, 0);

        // random alert patterns
        for (int n = 0; n < 200; n++) begin
            set_faults(5'($urandom() & (($urandom() % 3 == 0) ? 5'h1F : 5'h0)),
                       NG'($urandom()), NG'($urandom()), 1'($urandom() % 4 != 0));
            chk("R1 R2 R3 random pattern", alert_pull, exp_alert());
        end

        // R6 R8 directed ARA with alert, R/W bit both values
        own = 7'b1011001;
        set_faults(5'b00001, '0, '0, 1'b1);
        ara_txn({ARA, 1'b1}, -1, ack, rd);
        chk("R6 ack with rw=1", ack, 1);
        chk("R8 returned address", rd, {own, 1'b0});
        ara_txn({ARA, 1'b0}, -1, ack, rd);
        chk("R6 ack with rw=0", ack, 1);
        chk("R8 returned address rw=0", rd, {own, 1'b0});
        chk("R10 alert kept after ARA", alert_pull, 1);
        chk("R4 sda released after txn", sda_oe, 0);

        // R7: alert inactive -> no ack
        set_faults(5'b00000, '0, '0, 1'b1);
        ara_txn({ARA, 1'b1}, -1, ack, rd);
        chk("R7 nack without alert", ack, 0);
        chk("R7 no data without alert", rd, 8'hFF);
        // R7: other address
        set_faults(5'b01000, '0, '0, 1'b1);
        ara_txn(8'h5B, -1, ack, rd);
        chk("R7 nack other address", ack, 0);
        chk("R7 no data other address", rd, 8'hFF);

        // R9: arbitration loss on bit7 where own has a 1
        own = 7'b1000000;
        ara_txn({ARA, 1'b1}, 7, ack, rd);
        chk("R9 ack before arbitration", ack, 1);
        chk("R9 backed off after loss", rd, 8'h7F);
        // loss on a middle bit
        own = 7'b0010000;
        ara_txn({ARA, 1'b1}, 5, ack, rd);
        chk("R9 mid-byte loss", rd, 8'h1F);

        // R11: STOP mid-read while released
        own = 7'b0100000;
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(ab_bit({ARA, 1'b1}, i), s);
        bus_bit(1'b1, s);
        chk("R6 ack before stop test", s, 0);
        bus_bit(1'b1, s);
        chk("R8 first data bit", s, 0);
        bus_stop();
        waitq(4);
        chk("R11 stop releases sda", sda_oe, 0);
        ara_txn({ARA, 1'b1}, -1, ack, rd);
        chk("R11 recovered after stop", rd, {own, 1'b0});

        // R11: repeated START mid-address restarts reception
        bus_start();
        for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
        m_sda = 1; waitq(Q); m_scl = 1; waitq(Q); m_sda = 0; waitq(Q); m_scl = 0; waitq(Q);
        for (int i = 7; i >= 0; i--) bus_bit(ab_bit({ARA, 1'b0}, i), s);
        bus_bit(1'b1, s);
        chk("R11 repeated start then ack", s, 0);
        for (int i = 0; i < 9; i++) bus_bit(1'b1, s);
        bus_stop();
        chk("R5 idle after repeated-start txn", sda_oe, 0);

        // random exchanges
        for (int n = 0; n < 12; n++) begin
            own = 7'($urandom());
            fx  = 5'($urandom() & 5'h11);
            set_faults(fx, NG'($urandom()), NG'($urandom()), 1'b1);
            ab = {ARA, 1'($urandom())};
            if (n % 4 == 3) ab = {7'($urandom() | 7'h40), 1'b0};
            ara_txn(ab, -1, ack, rd);
            if (ab[7:1] == ARA && exp_alert()) begin
                chk("R6 random ack", ack, 1);
                chk("R8 random address", rd, {own, 1'b0});
            end else begin
                chk("R7 random nack", ack, 0);
                chk("R7 random released", rd, 8'hFF);
            end
            chk("R10 alert follows faults", alert_pull, exp_alert());
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic ab_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction
endmodule